// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides when a regulator output may be reported as good. It watches a digitized feedback code against an undervoltage/overvoltage window that has hysteresis on both edges, together with the enable input, the supply power-on-reset status and the soft-start-complete flag. When these conditions first all hold, a counter starts counting switching-cycle ticks. The good indication is released only after the conditions have held, without a break, for a fixed number of ticks.

The output `pad_pull_en` drives an open-drain pad. A value of 1 pulls the pad low and reports "not good". A value of 0 releases the pad and reports "good". A loss of any qualifying condition pulls the pad low combinationally, in the same clock in which the input changes, and clears the qualification count. A later recovery must then wait a full qualification interval again. The pad driver and the analog comparators sit outside this block.

The default thresholds assume a reference code of 800:
- Overvoltage sets at 880 (110 %) and clears at 856 (107 %).
- Undervoltage sets at 720 (90 %) and clears at 744 (93 %).

Top module: `pgood_window_mon`

## Requirements
- R1: While `rst_n` is low, `pad_pull_en` is 1 and the qualification count is zero. On reset the comparator state is undervoltage-active and overvoltage-inactive. With `fb_code` at 800, the undervoltage state clears on the first clock after reset.
- R2: `pad_pull_en` goes to 0 only when `en`, `por_ok` and `ss_done` are 1 and the feedback is in-window. These conditions must hold without a break for QUAL_CYCLES (1000) `cycle_tick` pulses. The pad is released in the clock that follows the edge at which the 1000th tick is sampled. `ss_done` at 0 keeps the pad pulled low.
- R3: Overvoltage trips when `fb_code` is 880 or more. `pad_pull_en` is then 1 in the same clock.
- R4: Undervoltage trips when `fb_code` is 720 or less. `pad_pull_en` is then 1 in the same clock.
- R5: A tripped overvoltage state clears only when `fb_code` is 856 or less. A tripped undervoltage state clears only when `fb_code` is 744 or more. Codes between the trip and clear points keep the pad pulled low.
- R6: Any loss of qualification during the count restarts the count from zero. This includes an excursion lasting a single clock.
- R7: `en` at 0, `por_ok` at 0 or `ss_done` at 0 forces `pad_pull_en` to 1 in the same clock.
- R8: After an excursion ends, the pad is released again only after another full 1000 qualifying ticks.
- R9: Once the pad is released, the count saturates. The pad stays released under any number of further ticks while qualification holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | One-clock pulse per switching cycle |
| en | input | 1 | Converter enable |
| por_ok | input | 1 | Supply power-on-reset is satisfied |
| ss_done | input | 1 | Soft-start has finished |
| fb_code | input | 11 | Digitized feedback voltage code |
| pad_pull_en | output | 1 | 1 pulls the open-drain pad low ("not good") |

## Verification
A comparator state stuck on the wrong side of its hysteresis band would show within one clock of `fb_code` entering the band between trip and clear point. The pad would then be released too early or held low too long. A counter that fails to clear on an excursion would show as a release up to a full qualification interval early, roughly 2000 clocks at the tick rate the bench uses. The bench compares the pad against an independent behavioural model on every clock, so any of these faults produces a miscompare on the first affected cycle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef struct packed {
        logic uv;
        logic ov;
    } win_flags_t;

    localparam win_flags_t WIN_RESET = '{uv: 1'b1, ov: 1'b0};

endpackage

// File: rtl/pgw_window_cmp.sv
module pgw_window_cmp
    import pgw_pkg::*;
#(
    parameter int FB_W     = 11,
    parameter int REF_CODE = 800,
    parameter int OV_PCT   = 110,
    parameter int UV_PCT   = 90,
    parameter int HYST_PCT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    output logic            in_window
);

    localparam logic [FB_W-1:0] OV_SET = FB_W'((REF_CODE * OV_PCT) / 100);
    localparam logic [FB_W-1:0] OV_CLR = FB_W'((REF_CODE * (OV_PCT - HYST_PCT)) / 100);
    localparam logic [FB_W-1:0] UV_SET = FB_W'((REF_CODE * UV_PCT) / 100);
    localparam logic [FB_W-1:0] UV_CLR = FB_W'((REF_CODE * (UV_PCT + HYST_PCT)) / 100);

    win_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (flags_q.ov) flags_d.ov = (fb_code > OV_CLR);
        else            flags_d.ov = (fb_code >= OV_SET);
        if (flags_q.uv) flags_d.uv = (fb_code < UV_CLR);
        else            flags_d.uv = (fb_code <= UV_SET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= WIN_RESET;
        else        flags_q <= flags_d;
    end

    assign in_window = !flags_d.uv && !flags_d.ov;

endmodule

// File: rtl/pgw_qual_ctr.sv
module pgw_qual_ctr #(
    parameter int QUAL_CYCLES = 1000,
    parameter int CNT_W       = $clog2(QUAL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic qualify,
    output logic good
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             good;
    } qual_state_t;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!qualify) begin
            st_d.cnt  = '0;
            st_d.good = 1'b0;
        end else begin
            if (tick && (st_q.cnt < LIMIT)) st_d.cnt = st_q.cnt + 1'b1;
            st_d.good = (st_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign good = st_q.good;

endmodule

// File: rtl/pgood_window_mon.sv
module pgood_window_mon #(
    parameter int FB_W        = 11,
    parameter int REF_CODE    = 800,
    parameter int OV_PCT      = 110,
    parameter int UV_PCT      = 90,
    parameter int HYST_PCT    = 3,
    parameter int QUAL_CYCLES = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cycle_tick,
    input  logic            en,
    input  logic            por_ok,
    input  logic            ss_done,
    input  logic [FB_W-1:0] fb_code,
    output logic            pad_pull_en
);

    logic in_window;
    logic qualify;
    logic good_q;

    pgw_window_cmp #(
        .FB_W(FB_W), .REF_CODE(REF_CODE), .OV_PCT(OV_PCT),
        .UV_PCT(UV_PCT), .HYST_PCT(HYST_PCT)
    ) cmp_i (
        .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .in_window(in_window)
    );

    assign qualify = en && por_ok && ss_done && in_window;

    pgw_qual_ctr #(.QUAL_CYCLES(QUAL_CYCLES)) ctr_i (
        .clk(clk), .rst_n(rst_n), .tick(cycle_tick),
        .qualify(qualify), .good(good_q)
    );

    assign pad_pull_en = !(good_q && qualify);

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
    parameter int FB_W     = 11,
    parameter int REF_CODE = 800,
    parameter int OV_PCT   = 110,
    parameter int UV_PCT   = 90
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cycle_tick,
    input logic            en,
    input logic            por_ok,
    input logic            ss_done,
    input logic [FB_W-1:0] fb_code,
    input logic            pad_pull_en
);

    localparam logic [FB_W-1:0] OV_SET = FB_W'((REF_CODE * OV_PCT) / 100);
    localparam logic [FB_W-1:0] UV_SET = FB_W'((REF_CODE * UV_PCT) / 100);

    // R7
    disabled_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !por_ok) |-> pad_pull_en);

    // R2
    no_good_before_softstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |-> pad_pull_en);

    // R3
    ov_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_code >= OV_SET) |-> pad_pull_en);

    // R4
    uv_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_code <= UV_SET) |-> pad_pull_en);

    // R2
    release_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_pull_en) |-> $past(cycle_tick));

endmodule

bind pgood_window_mon pgw_chk #(
    .FB_W(FB_W), .REF_CODE(REF_CODE), .OV_PCT(OV_PCT), .UV_PCT(UV_PCT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .en(en),
    .por_ok(por_ok), .ss_done(ss_done), .fb_code(fb_code),
    .pad_pull_en(pad_pull_en)
);

// File: tb/pgood_window_mon_tb_top.sv
module pgood_window_mon_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cycle_tick = 1'b0;
    logic        en = 1'b0;
    logic        por_ok = 1'b0;
    logic        ss_done = 1'b0;
    logic [10:0] fb_code = 11'd800;
    logic        pad_pull_en;

    integer n_vec = 0;
    integer n_bad = 0;
    integer tick_per = 2;
    integer tctr = 0;
    bit     finished = 0;

    // behavioural reference state
    integer m_uv = 1, m_ov = 0, m_cnt = 0, m_pg = 0;

    always #4 clk = ~clk;

    pgood_window_mon dut_i (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .en(en),
        .por_ok(por_ok), .ss_done(ss_done), .fb_code(fb_code),
        .pad_pull_en(pad_pull_en)
    );

    initial begin
        forever begin
            @(posedge clk);
            #1;
            tctr = tctr + 1;
            if (tctr >= tick_per) begin
                tctr = 0;
                cycle_tick = 1'b1;
            end else begin
                cycle_tick = 1'b0;
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        integer uv_n, ov_n, ok, expv;
        uv_n = (m_uv != 0) ? (fb_code < 744) : (fb_code <= 720);
        ov_n = (m_ov != 0) ? (fb_code > 856) : (fb_code >= 880);
        ok   = (rst_n && en && por_ok && ss_done && !uv_n && !ov_n) ? 1 : 0;
        expv = (rst_n && m_pg != 0 && ok != 0) ? 0 : 1;
        n_vec = n_vec + 1;
        if (pad_pull_en !== expv[0]) begin
            n_bad = n_bad + 1;
            $display("FAIL model(R2) t=%0t pad_pull_en act=%b exp=%0d", $time, pad_pull_en, expv);
        end
        if (!rst_n) begin
            m_uv = 1; m_ov = 0; m_cnt = 0; m_pg = 0;
        end else begin
            m_uv = uv_n; m_ov = ov_n;
            if (ok == 0) begin
                m_cnt = 0; m_pg = 0;
            end else begin
                if (cycle_tick && m_cnt < 1000) m_cnt = m_cnt + 1;
                m_pg = (m_cnt == 1000) ? 1 : 0;
            end
        end
    end

    task automatic drive_sync();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_clk(input integer n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(input logic expv, input string tag);
        @(negedge clk);
        n_vec = n_vec + 1;
        if (pad_pull_en !== expv) begin
            n_bad = n_bad + 1;
            $display("FAIL %s pad_pull_en act=%b exp=%b", tag, pad_pull_en, expv);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        en = 1; por_ok = 1; ss_done = 0; fb_code = 11'd800;
        wait_clk(5);
        check(1'b1, "R1 reset holds pad low");
        drive_sync(); rst_n = 1;
        wait_clk(2500);
        check(1'b1, "R2 no release before soft-start done");
        drive_sync(); ss_done = 1;
        wait_clk(1900);
        check(1'b1, "R2 still counting");
        wait_clk(200);
        check(1'b0, "R2 released after qualification");
        wait_clk(3000);
        check(1'b0, "R9 saturated stays released");
        drive_sync(); fb_code = 11'd880;
        check(1'b1, "R3 ov trip same clock");
        drive_sync(); fb_code = 11'd870;
        wait_clk(2200);
        check(1'b1, "R5 ov hysteresis holds");
        drive_sync(); fb_code = 11'd856;
        wait_clk(2100);
        check(1'b0, "R8 re-qualified after ov");
        drive_sync(); fb_code = 11'd720;
        check(1'b1, "R4 uv trip same clock");
        drive_sync(); fb_code = 11'd740;
        wait_clk(2200);
        check(1'b1, "R5 uv hysteresis holds");
        drive_sync(); fb_code = 11'd744;
        wait_clk(1000);
        drive_sync(); fb_code = 11'd700;
        drive_sync(); fb_code = 11'd800;
        wait_clk(1500);
        check(1'b1, "R6 glitch restarted count");
        wait_clk(600);
        check(1'b0, "R6 released after full restart");
        drive_sync(); en = 0;
        check(1'b1, "R7 enable low");
        drive_sync(); en = 1;
        wait_clk(2100);
        check(1'b0, "R8 re-qualified after enable");
        drive_sync(); por_ok = 0;
        check(1'b1, "R7 por lost");
        drive_sync(); por_ok = 1;
        wait_clk(2100);
        check(1'b0, "R8 re-qualified after por");
        drive_sync(); ss_done = 0;
        check(1'b1, "R7 soft-start flag low");
        drive_sync(); rst_n = 0;
        check(1'b1, "R1 reset mid-run");
        wait_clk(3);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule